// File: doc/BRIEF.md
# Nonvolatile Preset Save/Restore Sequencer

This block is the storage side of a digitally controlled trimmer. It keeps the live wiper register and a small array of stored words. Word 0 is the wiper preset and the other words are general-purpose user words. A command decoder sends it one-cycle command strobes, each with a 4-bit opcode, an address and a data field. The block then writes the wiper, saves into the stored array, restores the preset or reads a value back. An active-low reload pin and the end of reset also trigger restores.

Saves, timed restores and reads each run for a programmed number of clock cycles. During that time `ready` is low and any new command is refused. A refused command is recorded in a sticky flag. The stored array is a behavioural register file: a save writes its word on the last cycle of the save delay. While the write-protect input is low, the commands that change the wiper or the stored words have no effect. All restore paths and all reads still work while write-protect is low.

Top module: `trim_nv_seq`

## Requirements
- R1: During reset `ready` is 0 and `wiper` is 0. After reset is released, `ready` stays low for LOAD_CYC cycles and then rises. At that moment `wiper` takes the stored preset. Stored words reset to midscale (0x200) for word 0 and to zero for every other word.
- R2: Opcode 11 loads `cmd_data` into `wiper` on the next clock edge. `ready` stays high.
- R3: Opcode 2 saves `wiper` into word 0. Opcode 3 saves into word `cmd_addr`: the value is `wiper` when the address is 0 and `cmd_data` otherwise. Both hold `ready` low for SAVE_CYC cycles, and the word is written when `ready` returns high. `wiper` does not change during a save.
- R4: Opcode 1 copies word 0 into `wiper` on the next edge and keeps `ready` high. Opcode 8 does the same copy but holds `ready` low for LOAD_CYC cycles and updates `wiper` when `ready` rises.
- R5: Opcode 9 returns stored word `cmd_addr` and opcode 10 returns `wiper`. Each holds `ready` low for READ_CYC cycles. The value then appears on `rd_data`, and `rd_valid` pulses high for exactly the first cycle in which `ready` is high again.
- R6: While the synchronised `reload_n` is low and the block is idle, `wiper` is forced to midscale and `ready` is low. After `reload_n` returns high, `ready` stays low for LOAD_CYC more cycles. Then `wiper` takes word 0.
- R7: While `protect_n` is 0, opcodes 2, 3 and 11 have no effect: `ready` stays high and neither `wiper` nor the stored words change. Opcodes 1, 8, 9 and 10 and the reload pin still work.
- R8: A command strobe that arrives while `ready` is low, or while the reload pin holds the block, is ignored. It sets `dropped`, which stays set until reset.
- R9: Opcodes 0, 4 to 7 and 12 to 15 change nothing. `ready` stays high and `wiper` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | ADDR_W (4) | Stored-word address |
| cmd_data | input | WIDTH (10) | Data field |
| protect_n | input | 1 | Active-low write protect |
| reload_n | input | 1 | Asynchronous active-low reload pin |
| wiper | output | WIDTH (10) | Live wiper register |
| ready | output | 1 | High when idle and accepting commands |
| rd_data | output | WIDTH (10) | Last read-back value |
| rd_valid | output | 1 | One-cycle pulse when rd_data is updated |
| dropped | output | 1 | Sticky flag for refused commands |

## Verification
The assertions check the following on every cycle:
- `wiper` sits at midscale for as long as the reload pin holds the block.
- `wiper` cannot move during a save or a read.
- A strobe that arrives while busy always raises `dropped`, and `dropped` never clears.
- Protected writes leave `ready` high and `wiper` unchanged.
- `rd_valid` only appears while the block is idle.

Only the bench scenarios can show the following:
- The exact busy length of each operation.
- The data that a save leaves in the stored array and that a later read returns.
- The choice between `wiper` and `cmd_data` for a store at address 0.
- The value restored after reset and after a reload pulse.

// File: rtl/trim_nv_pkg.sv
`timescale 1ns/1ps
package trim_nv_pkg;

  // Opcode values decoded by the sequencer
  localparam logic [3:0] OP_RESTORE_NOW   = 4'd1;
  localparam logic [3:0] OP_SAVE_PRESET   = 4'd2;
  localparam logic [3:0] OP_STORE         = 4'd3;
  localparam logic [3:0] OP_RESTORE_TIMED = 4'd8;
  localparam logic [3:0] OP_READ_WORD     = 4'd9;
  localparam logic [3:0] OP_READ_WIPER    = 4'd10;
  localparam logic [3:0] OP_WRITE_WIPER   = 4'd11;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_SAVE,
    ST_LOAD,
    ST_READ,
    ST_HOLD
  } seq_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/trim_nv_sync.sv
`timescale 1ns/1ps
module trim_nv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nx;

  always_comb begin
    chain_nx = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_nx;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/trim_nv_store.sv
`timescale 1ns/1ps
module trim_nv_store #(
  parameter int               WIDTH       = 10,
  parameter int               ADDR_W      = 4,
  parameter logic [WIDTH-1:0] PRESET_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  preset
);
  localparam int WORDS = 1 << ADDR_W;

  logic [WIDTH-1:0] word_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    localparam logic [WIDTH-1:0] INIT = (i == 0) ? PRESET_INIT : '0;
    logic             hit;
    logic [WIDTH-1:0] cell_q;

    assign hit = we && (waddr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q <= INIT;
      else if (hit) cell_q <= wdata;
    end

    assign word_q[i] = cell_q;
  end

  assign rdata  = word_q[raddr];
  assign preset = word_q[0];
endmodule

// File: rtl/trim_nv_ctrl.sv
`timescale 1ns/1ps
module trim_nv_ctrl
  import trim_nv_pkg::*;
#(
  parameter int WIDTH    = 10,
  parameter int ADDR_W   = 4,
  parameter int SAVE_CYC = 5000000,
  parameter int LOAD_CYC = 200,
  parameter int READ_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WIDTH-1:0]  cmd_data,
  input  logic              protect_n,
  input  logic              pin_s,
  input  logic [WIDTH-1:0]  preset_word,
  input  logic [WIDTH-1:0]  stored_word,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  wiper,
  output logic              ready,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rd_valid,
  output logic              dropped
);
  localparam logic [WIDTH-1:0] MID = WIDTH'(1) << (WIDTH - 1);
  localparam int CNT_MAX = max3(SAVE_CYC, LOAD_CYC, READ_CYC);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e        state_q, state_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [WIDTH-1:0]  wiper_q, wiper_nx;
  logic [WIDTH-1:0]  pend_word_q, pend_word_nx;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_nx;
  logic [WIDTH-1:0]  rd_data_q, rd_data_nx;
  logic              rd_valid_q, rd_valid_nx;
  logic              dropped_q, dropped_nx;
  logic              wr_ok;
  logic              idle;

  assign idle  = (state_q == ST_IDLE);
  assign wr_ok = protect_n;

  always_comb begin
    state_nx     = state_q;
    cnt_nx       = cnt_q;
    wiper_nx     = wiper_q;
    pend_word_nx = pend_word_q;
    pend_addr_nx = pend_addr_q;
    rd_data_nx   = rd_data_q;
    rd_valid_nx  = 1'b0;
    dropped_nx   = dropped_q | (cmd_valid && (!idle || !pin_s));
    we           = 1'b0;

    unique case (state_q)
      ST_BOOT, ST_LOAD: begin
        if (cnt_q == '0) begin
          wiper_nx = preset_word;
          state_nx = ST_IDLE;
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
      ST_SAVE: begin
        if (cnt_q == '0) begin
          we       = 1'b1;
          state_nx = ST_IDLE;
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
      ST_READ: begin
        if (cnt_q == '0) begin
          rd_data_nx  = pend_word_q;
          rd_valid_nx = 1'b1;
          state_nx    = ST_IDLE;
        end else begin
          cnt_nx = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        wiper_nx = MID;
        if (pin_s) begin
          state_nx = ST_LOAD;
          cnt_nx   = CNT_W'(LOAD_CYC - 1);
        end
      end
      default: begin // ST_IDLE
        if (!pin_s) begin
          wiper_nx = MID;
          state_nx = ST_HOLD;
        end else if (cmd_valid) begin
          case (cmd_op)
            OP_RESTORE_NOW: wiper_nx = preset_word;
            OP_SAVE_PRESET: begin
              if (wr_ok) begin
                pend_addr_nx = '0;
                pend_word_nx = wiper_q;
                state_nx     = ST_SAVE;
                cnt_nx       = CNT_W'(SAVE_CYC - 1);
              end
            end
            OP_STORE: begin
              if (wr_ok) begin
                pend_addr_nx = cmd_addr;
                pend_word_nx = (cmd_addr == '0) ? wiper_q : cmd_data;
                state_nx     = ST_SAVE;
                cnt_nx       = CNT_W'(SAVE_CYC - 1);
              end
            end
            OP_RESTORE_TIMED: begin
              state_nx = ST_LOAD;
              cnt_nx   = CNT_W'(LOAD_CYC - 1);
            end
            OP_READ_WORD: begin
              pend_word_nx = stored_word;
              state_nx     = ST_READ;
              cnt_nx       = CNT_W'(READ_CYC - 1);
            end
            OP_READ_WIPER: begin
              pend_word_nx = wiper_q;
              state_nx     = ST_READ;
              cnt_nx       = CNT_W'(READ_CYC - 1);
            end
            OP_WRITE_WIPER: begin
              if (wr_ok) wiper_nx = cmd_data;
            end
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_BOOT;
      cnt_q       <= CNT_W'(LOAD_CYC - 1);
      wiper_q     <= '0;
      pend_word_q <= '0;
      pend_addr_q <= '0;
      rd_data_q   <= '0;
      rd_valid_q  <= 1'b0;
      dropped_q   <= 1'b0;
    end else begin
      state_q     <= state_nx;
      cnt_q       <= cnt_nx;
      wiper_q     <= wiper_nx;
      pend_word_q <= pend_word_nx;
      pend_addr_q <= pend_addr_nx;
      rd_data_q   <= rd_data_nx;
      rd_valid_q  <= rd_valid_nx;
      dropped_q   <= dropped_nx;
    end
  end

  assign waddr    = pend_addr_q;
  assign wdata    = pend_word_q;
  assign wiper    = wiper_q;
  assign ready    = idle;
  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign dropped  = dropped_q;

  AST_HOLD_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> (wiper_q == MID)); // R6

  AST_BUSY_WIPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAVE || state_q == ST_READ) |=> $stable(wiper_q)); // R3

  AST_BUSY_CMD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ready) |=> dropped_q); // R8

  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dropped_q |=> dropped_q); // R8

  AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ready && pin_s && !protect_n &&
     (cmd_op == OP_WRITE_WIPER || cmd_op == OP_SAVE_PRESET || cmd_op == OP_STORE))
    |=> (ready && $stable(wiper_q))); // R7

  AST_RDVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> ready); // R5
endmodule

// File: rtl/trim_nv_seq.sv
`timescale 1ns/1ps
module trim_nv_seq #(
  parameter int WIDTH    = 10,
  parameter int ADDR_W   = 4,
  parameter int SAVE_CYC = 5000000,
  parameter int LOAD_CYC = 200,
  parameter int READ_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WIDTH-1:0]  cmd_data,
  input  logic              protect_n,
  input  logic              reload_n,
  output logic [WIDTH-1:0]  wiper,
  output logic              ready,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rd_valid,
  output logic              dropped
);
  localparam logic [WIDTH-1:0] MID = WIDTH'(1) << (WIDTH - 1);

  logic              pin_s;
  logic              st_we;
  logic [ADDR_W-1:0] st_waddr;
  logic [WIDTH-1:0]  st_wdata;
  logic [WIDTH-1:0]  st_rdata;
  logic [WIDTH-1:0]  st_preset;

  trim_nv_sync #(.STAGES(2), .RST_VAL(1'b1)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (reload_n),
    .dout (pin_s)
  );

  trim_nv_store #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .PRESET_INIT(MID)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .raddr (cmd_addr),
    .rdata (st_rdata),
    .preset(st_preset)
  );

  trim_nv_ctrl #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W),
    .SAVE_CYC(SAVE_CYC), .LOAD_CYC(LOAD_CYC), .READ_CYC(READ_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .protect_n  (protect_n),
    .pin_s      (pin_s),
    .preset_word(st_preset),
    .stored_word(st_rdata),
    .we         (st_we),
    .waddr      (st_waddr),
    .wdata      (st_wdata),
    .wiper      (wiper),
    .ready      (ready),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .dropped    (dropped)
  );
endmodule

// File: tb/trim_nv_seq_bench.sv
`timescale 1ns/1ps
module trim_nv_seq_bench;
  localparam int SAVE = 20;
  localparam int LOAD = 5;
  localparam int READ = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [3:0] cmd_op;
  logic [3:0] cmd_addr;
  logic [9:0] cmd_data;
  logic       protect_n;
  logic       reload_n;
  logic [9:0] wiper;
  logic       ready;
  logic [9:0] rd_data;
  logic       rd_valid;
  logic       dropped;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  trim_nv_seq #(.SAVE_CYC(SAVE), .LOAD_CYC(LOAD), .READ_CYC(READ)) u_trim_nv_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .protect_n(protect_n),
    .reload_n(reload_n), .wiper(wiper), .ready(ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .dropped(dropped)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] addr, input logic [9:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // op, addr, data, busy cycles, check read, expected wiper, expected read
  localparam logic [46:0] VEC [18] = '{
    {4'd11, 4'd0,  10'h155, 8'd0,  1'b0, 10'h155, 10'h000}, // R2 write wiper
    {4'd10, 4'd0,  10'h000, 8'd2,  1'b1, 10'h155, 10'h155}, // R5 read wiper
    {4'd2,  4'd0,  10'h000, 8'd20, 1'b0, 10'h155, 10'h000}, // R3 save preset
    {4'd11, 4'd0,  10'h3FF, 8'd0,  1'b0, 10'h3FF, 10'h000}, // R2 full scale
    {4'd9,  4'd0,  10'h000, 8'd2,  1'b1, 10'h3FF, 10'h155}, // R5 R3 preset stored
    {4'd1,  4'd0,  10'h000, 8'd0,  1'b0, 10'h155, 10'h000}, // R4 fast restore
    {4'd3,  4'd5,  10'h0AB, 8'd20, 1'b0, 10'h155, 10'h000}, // R3 user word
    {4'd9,  4'd5,  10'h000, 8'd2,  1'b1, 10'h155, 10'h0AB}, // R5 read user word
    {4'd9,  4'd6,  10'h000, 8'd2,  1'b1, 10'h155, 10'h000}, // R1 user word reset zero
    {4'd11, 4'd0,  10'h000, 8'd0,  1'b0, 10'h000, 10'h000}, // R2 zero scale
    {4'd8,  4'd0,  10'h000, 8'd5,  1'b0, 10'h155, 10'h000}, // R4 timed restore
    {4'd3,  4'd0,  10'h3C3, 8'd20, 1'b0, 10'h155, 10'h000}, // R3 addr 0 takes wiper
    {4'd11, 4'd0,  10'h2AA, 8'd0,  1'b0, 10'h2AA, 10'h000}, // R2
    {4'd9,  4'd0,  10'h000, 8'd2,  1'b1, 10'h2AA, 10'h155}, // R3 preset is wiper not data
    {4'd5,  4'd0,  10'h111, 8'd0,  1'b0, 10'h2AA, 10'h000}, // R9 unused opcode
    {4'd0,  4'd0,  10'h111, 8'd0,  1'b0, 10'h2AA, 10'h000}, // R9 no-op
    {4'd15, 4'd3,  10'h111, 8'd0,  1'b0, 10'h2AA, 10'h000}, // R9 unused opcode
    {4'd9,  4'd15, 10'h000, 8'd2,  1'b1, 10'h2AA, 10'h000}  // R5 last address
  };

  initial begin
    int n;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
    protect_n = 1'b1; reload_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", ready, 0);
    check("R1 wiper in reset", wiper, 0);
    check("R8 dropped in reset", dropped, 0);
    rst_n = 1'b1;
    wait_idle(n);
    check("R1 boot busy length", n, LOAD);
    check("R1 boot wiper = preset", wiper, 10'h200);

    for (int i = 0; i < 18; i++) begin
      logic [46:0] v;
      v = VEC[i];
      issue(v[46:43], v[42:39], v[38:29]);
      wait_idle(n);
      check($sformatf("R2-R9 row %0d busy", i), n, int'(v[28:21]));
      check($sformatf("R2-R9 row %0d wiper", i), wiper, int'(v[19:10]));
      if (v[20]) begin
        check($sformatf("R5 row %0d rd_valid", i), rd_valid, 1);
        check($sformatf("R5 row %0d rd_data", i), rd_data, int'(v[9:0]));
      end
    end
    check("R8 no drops yet", dropped, 0);

    // R8: command during a save is refused and flagged
    issue(4'd2, 4'd0, 10'h000);
    cmd_valid = 1'b1; cmd_op = 4'd11; cmd_data = 10'h001;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle(n);
    check("R8 dropped set", dropped, 1);
    check("R8 wiper untouched by refused write", wiper, 10'h2AA);
    repeat (3) @(negedge clk);
    check("R8 dropped sticky", dropped, 1);

    // R7: write protect
    issue(4'd11, 4'd0, 10'h100);
    protect_n = 1'b0;
    issue(4'd11, 4'd0, 10'h123);
    check("R7 protected write ready", ready, 1);
    check("R7 protected write wiper", wiper, 10'h100);
    issue(4'd2, 4'd0, 10'h000);
    check("R7 protected save no busy", ready, 1);
    issue(4'd3, 4'd7, 10'h077);
    check("R7 protected store no busy", ready, 1);
    issue(4'd9, 4'd7, 10'h000);
    wait_idle(n);
    check("R7 user word unchanged", rd_data, 10'h000);
    issue(4'd9, 4'd0, 10'h000);
    wait_idle(n);
    check("R7 preset unchanged", rd_data, 10'h2AA);
    issue(4'd8, 4'd0, 10'h000);
    wait_idle(n);
    check("R7 R4 timed restore under protect", n, LOAD);
    check("R7 restore wiper", wiper, 10'h2AA);

    // R6: reload pin, still protected
    @(negedge clk);
    reload_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 wiper midscale while held", wiper, 10'h200);
    check("R6 ready low while held", ready, 0);
    reload_n = 1'b1;
    wait_idle(n);
    check("R6 reload busy at least LOAD", int'(n >= LOAD), 1);
    check("R6 wiper reloaded", wiper, 10'h2AA);
    protect_n = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule